// File: doc/BRIEF.md
# Handshaked Parallel Input Port

This block receives bytes from a slow peripheral over an 8-bit parallel bus and hands them to a host. The peripheral signals through an active-low strobe/request line, and the port answers on an acknowledge line. A static configuration input selects one of three synchronisation protocols.

- **Plain strobe latching.** Each strobe captures a byte, and the acknowledge line is not used.
- **Single handshake.** The port captures on the strobe and then acknowledges the transfer.
- **Four-phase double handshake.** The port first signals that it is ready. It then latches on the second request edge and holds acknowledge until the host has consumed the byte.

On the host side, the port keeps the last captured byte in a holding register, with a data-valid flag. A one-cycle read pulse consumes the byte. A read made while nothing is valid leaves the byte in place and raises an underrun pulse. The request line goes through a two-flop synchroniser, and edges are found on the synchronised copy. A mode change takes effect only while the protocol engine is idle.

Top module: `par_hs_rx`

## Requirements
- R1: While reset is high and after it is released, `rd_valid`, `pin_ack` and `rd_underrun` are 0, `rd_data` is 0 and `mode_active` is 0.
- R2: The encoding of `cfg_mode` is: 0 for strobe latching, 1 for single handshake, 2 for double handshake. In mode 0, a falling edge on `pin_req_n` (active low) captures `pin_data`. `rd_valid` reads 1 after the third rising clock edge that follows the fall, and `pin_ack` stays 0.
- R3: In mode 0, a new strobe while a byte is still unread replaces the held byte, and `rd_valid` stays 1.
- R4: In mode 1, a falling edge on `pin_req_n` captures the byte, and `pin_ack` rises on the same edge as `rd_valid`. `pin_ack` returns to 0 on the third rising edge after `pin_req_n` returns high.
- R5: In mode 2, `pin_req_n` held low with no unread byte raises `pin_ack` to signal readiness, and no byte is captured in this phase.
- R6: In mode 2, once `pin_ack` is high, `pin_req_n` going high and then low again captures `pin_data`.
- R7: In mode 2, `pin_ack` stays high after capture until a host read consumes the byte. It then drops on that read edge. A new readiness answer is given only after `pin_req_n` has returned high and gone low again.
- R8: In mode 2, `pin_ack` is not raised while a previously captured byte is unread.
- R9: A read pulse while `rd_valid` is 1 clears `rd_valid` on that edge, and `rd_data` keeps its value.
- R10: A read pulse while `rd_valid` is 0 sets `rd_underrun` to 1 for the following cycle and leaves `rd_data` unchanged.
- R11: `mode_active` follows `cfg_mode` only while the protocol engine is idle, and code 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 2 | Protocol select: 0 strobe, 1 single, 2 double, 3 ignored |
| pin_data | input | DATA_W | Parallel data from the peripheral |
| pin_req_n | input | 1 | Strobe/request from the peripheral, active low, asynchronous |
| pin_ack | output | 1 | Acknowledge/ready to the peripheral, registered |
| rd_en | input | 1 | Host read pulse |
| rd_data | output | DATA_W | Held byte |
| rd_valid | output | 1 | Held byte is unread |
| rd_underrun | output | 1 | One-cycle pulse after a read with no valid byte |
| mode_active | output | 2 | Protocol currently in force |

## Verification
A protocol engine stuck in the wrong state shows up at the acknowledge pin within a few cycles. Acknowledge either stays high after a read, or rises while a byte is unread, or never answers a request. A broken holding register shows as a wrong, lost or duplicated byte the next time the scoreboard monitor reads. Timing faults in the synchroniser path move the capture edge away from the third clock after the strobe, and the bench samples exactly there. Mode-latch faults show in `mode_active` one cycle after the engine returns to idle.

// File: rtl/par_hs_rx_pkg.sv
package par_hs_rx_pkg;
  typedef enum logic [1:0] {
    MODE_STROBE = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_DOUBLE = 2'd2,
    MODE_RSVD   = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SACK  = 3'd1,
    ST_DRDY  = 3'd2,
    ST_DWAIT = 3'd3,
    ST_DHELD = 3'd4,
    ST_DREL  = 3'd5
  } state_e;
endpackage

// File: rtl/par_hs_rx_sync.sv
module par_hs_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic lvl,
  output logic fall
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] chain;
  logic         prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[TOP-1:0], d};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= chain[TOP];
  end

  assign lvl  = chain[TOP];
  assign fall = prev & ~chain[TOP];
endmodule

// File: rtl/par_hs_rx_hold.sv
module par_hs_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch,
  input  logic [DATA_W-1:0] din,
  input  logic              rd,
  output logic [DATA_W-1:0] data_q,
  output logic              valid_q,
  output logic              underrun_q,
  output logic              consume
);
  assign consume = rd & valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q     <= '0;
      valid_q    <= 1'b0;
      underrun_q <= 1'b0;
    end else begin
      underrun_q <= rd & ~valid_q;
      if (latch) begin
        data_q  <= din;
        valid_q <= 1'b1;
      end else if (consume) begin
        valid_q <= 1'b0;
      end
    end
  end

  assert_latch_sets_valid_R2: assert property (@(posedge clk) disable iff (rst)
    latch |=> (valid_q && data_q == $past(din)));
  assert_data_held_R9: assert property (@(posedge clk) disable iff (rst)
    !latch |=> $stable(data_q));
  assert_read_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (rd && !latch) |=> !valid_q);
  assert_underrun_R10: assert property (@(posedge clk) disable iff (rst)
    (rd && !valid_q) |=> underrun_q);
endmodule

// File: rtl/par_hs_rx_ctrl.sv
module par_hs_rx_ctrl
  import par_hs_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cfg_mode,
  input  logic       lvl,
  input  logic       fall,
  input  logic       valid,
  input  logic       consume,
  output logic       latch,
  output logic       ack_q,
  output mode_e      act_mode
);
  state_e state, st_n;
  mode_e  mode_n;
  logic   ack_n;

  always_comb begin
    st_n   = state;
    ack_n  = ack_q;
    mode_n = act_mode;
    latch  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (cfg_mode != MODE_RSVD) mode_n = mode_e'(cfg_mode);
        case (act_mode)
          MODE_STROBE: latch = fall;
          MODE_SINGLE: if (fall) begin
            latch = 1'b1;
            ack_n = 1'b1;
            st_n  = ST_SACK;
          end
          MODE_DOUBLE: if (!lvl && !valid) begin
            ack_n = 1'b1;
            st_n  = ST_DRDY;
          end
          default: ;
        endcase
      end
      ST_SACK: if (lvl) begin
        ack_n = 1'b0;
        st_n  = ST_IDLE;
      end
      ST_DRDY:  if (lvl) st_n = ST_DWAIT;
      ST_DWAIT: if (fall) begin
        latch = 1'b1;
        st_n  = ST_DHELD;
      end
      ST_DHELD: if (consume) begin
        ack_n = 1'b0;
        st_n  = ST_DREL;
      end
      ST_DREL:  if (lvl) st_n = ST_IDLE;
      default: begin
        ack_n = 1'b0;
        st_n  = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ack_q    <= 1'b0;
      act_mode <= MODE_STROBE;
    end else begin
      state    <= st_n;
      ack_q    <= ack_n;
      act_mode <= mode_n;
    end
  end

  assert_idle_ack_low_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !ack_q);
  assert_no_ack_unread_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(ack_q) && $past(act_mode) == MODE_DOUBLE) |-> $past(!valid));
  assert_mode_in_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_mode) |-> $past(state == ST_IDLE));
  assert_mode_legal_R11: assert property (@(posedge clk) disable iff (rst)
    act_mode != MODE_RSVD);
  assert_ack_held_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DHELD && !consume) |=> ack_q);
endmodule

// File: rtl/par_hs_rx.sv
module par_hs_rx
  import par_hs_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_mode,
  input  logic [DATA_W-1:0] pin_data,
  input  logic              pin_req_n,
  output logic              pin_ack,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              rd_underrun,
  output logic [1:0]        mode_active
);
  logic  req_lvl, req_fall, latch, consume;
  mode_e act_mode;

  par_hs_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_req_n), .lvl(req_lvl), .fall(req_fall)
  );

  par_hs_rx_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .lvl(req_lvl), .fall(req_fall),
    .valid(rd_valid), .consume(consume), .latch(latch), .ack_q(pin_ack),
    .act_mode(act_mode)
  );

  par_hs_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .latch(latch), .din(pin_data), .rd(rd_en),
    .data_q(rd_data), .valid_q(rd_valid), .underrun_q(rd_underrun),
    .consume(consume)
  );

  assign mode_active = act_mode;
endmodule

// File: tb/tb_par_hs_rx.sv
module tb_par_hs_rx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_mode = 2'd0;
  logic [7:0] pin_data = 8'h00;
  logic       pin_req_n = 1'b1;
  logic       pin_ack, rd_valid, rd_underrun;
  logic [7:0] rd_data;
  logic [1:0] mode_active;
  logic       mon_rd = 1'b0, man_rd = 1'b0, mon_en = 1'b0;
  logic       rd_en;
  int         n_tests = 0, n_fail = 0;
  logic [7:0] exp_q[$];

  assign rd_en = mon_rd | man_rd;
  always #5 clk = ~clk;

  par_hs_rx dut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .pin_data(pin_data),
    .pin_req_n(pin_req_n), .pin_ack(pin_ack), .rd_en(rd_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_underrun(rd_underrun), .mode_active(mode_active)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard when a byte is valid and reads it (R2 R4 R6)
  initial begin
    forever begin
      @(negedge clk);
      if (mon_rd) mon_rd = 1'b0;
      else if (mon_en && rd_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected byte", rd_data, 0);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rd_data == e, "R6 scoreboard byte", rd_data, e);
        end
        mon_rd = 1'b1;
      end
    end
  end

  task automatic host_read();
    @(negedge clk); man_rd = 1'b1;
    @(negedge clk); man_rd = 1'b0;
  endtask

  task automatic strobe_byte(input logic [7:0] b);
    @(negedge clk); pin_data = b; pin_req_n = 1'b0;
    cyc(4); pin_req_n = 1'b1; cyc(4);
  endtask

  task automatic single_xfer(input logic [7:0] b);
    @(negedge clk); pin_data = b; pin_req_n = 1'b0;
    while (!pin_ack) @(negedge clk);
    pin_req_n = 1'b1;
    while (pin_ack) @(negedge clk);
    cyc(2);
  endtask

  task automatic dbl_xfer(input logic [7:0] b);
    @(negedge clk); pin_req_n = 1'b0;
    while (!pin_ack) @(negedge clk);
    pin_req_n = 1'b1; cyc(3);
    pin_data = b; pin_req_n = 1'b0;
    while (pin_ack) @(negedge clk);
    pin_req_n = 1'b1; cyc(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    cyc(5); rst = 1'b0; cyc(1);
    // R1 reset state
    chk(!rd_valid && !pin_ack && !rd_underrun, "R1 flags", {rd_valid, pin_ack, rd_underrun}, 0);
    chk(rd_data == 0 && mode_active == 0, "R1 data/mode", {rd_data, mode_active}, 0);

    // R2 strobe capture latency
    pin_data = 8'hA5; pin_req_n = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(!rd_valid, "R2 not yet valid", rd_valid, 0);
    @(posedge clk); @(negedge clk);
    chk(rd_valid && rd_data == 8'hA5, "R2 captured", rd_data, 8'hA5);
    chk(!pin_ack, "R2 ack unused", pin_ack, 0);
    cyc(3); pin_req_n = 1'b1; cyc(4);

    // R3 overwrite while unread
    strobe_byte(8'h3C);
    chk(rd_valid && rd_data == 8'h3C, "R3 overwrite", rd_data, 8'h3C);

    // R9 read clears valid, data kept
    host_read();
    chk(!rd_valid && rd_data == 8'h3C, "R9 read", {rd_valid, rd_data}, 8'h3C);

    // R10 underrun
    @(negedge clk); man_rd = 1'b1;
    @(negedge clk); man_rd = 1'b0;
    chk(rd_underrun == 1'b1, "R10 underrun pulse", rd_underrun, 1);
    chk(rd_data == 8'h3C, "R10 data unchanged", rd_data, 8'h3C);
    cyc(1);
    chk(rd_underrun == 1'b0, "R10 pulse ends", rd_underrun, 0);

    // R4 single handshake
    cfg_mode = 2'd1; cyc(3);
    chk(mode_active == 2'd1, "R11 mode to single", mode_active, 1);
    pin_data = 8'h5A; pin_req_n = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(!pin_ack && !rd_valid, "R4 before capture", {pin_ack, rd_valid}, 0);
    @(posedge clk); @(negedge clk);
    chk(pin_ack && rd_valid && rd_data == 8'h5A, "R4 ack with valid", {pin_ack, rd_valid, rd_data}, {2'b11, 8'h5A});
    cfg_mode = 2'd2; cyc(4);
    chk(pin_ack, "R4 ack held", pin_ack, 1);
    chk(mode_active == 2'd1, "R11 no change while busy", mode_active, 1);
    pin_req_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(pin_ack, "R4 ack before release", pin_ack, 1);
    @(posedge clk); @(negedge clk);
    chk(!pin_ack, "R4 ack released", pin_ack, 0);
    @(posedge clk); @(negedge clk);
    chk(mode_active == 2'd2, "R11 change at idle", mode_active, 2);

    // R8 backpressure: 5A still unread
    pin_req_n = 1'b0; cyc(8);
    chk(!pin_ack, "R8 no ready while unread", pin_ack, 0);
    host_read();
    chk(rd_data == 8'h5A, "R9 read byte", rd_data, 8'h5A);
    cyc(1);
    chk(pin_ack && !rd_valid, "R5 ready answered", {pin_ack, rd_valid}, 2'b10);

    // R6/R7 double handshake data phase
    pin_req_n = 1'b1; cyc(4);
    chk(!rd_valid && pin_ack, "R5 no capture on request", {rd_valid, pin_ack}, 2'b01);
    pin_data = 8'hC3; pin_req_n = 1'b0; cyc(4);
    chk(rd_valid && rd_data == 8'hC3, "R6 captured", rd_data, 8'hC3);
    cyc(4);
    chk(pin_ack, "R7 ack held until read", pin_ack, 1);
    host_read();
    chk(!pin_ack && !rd_valid, "R7 ack drops on read", {pin_ack, rd_valid}, 0);
    cyc(6);
    chk(!pin_ack, "R7 no rearm while low", pin_ack, 0);
    pin_req_n = 1'b1; cyc(5);
    chk(!pin_ack, "R7 idle high", pin_ack, 0);
    pin_req_n = 1'b0; cyc(4);
    chk(pin_ack, "R7 rearmed", pin_ack, 1);
    pin_req_n = 1'b1; cyc(4);
    mon_en = 1'b1;
    pin_data = 8'h7E; exp_q.push_back(8'h7E); pin_req_n = 1'b0;
    while (pin_ack) @(negedge clk);
    pin_req_n = 1'b1; cyc(4);

    // Scoreboard bursts in each mode
    for (int i = 0; i < 6; i++) begin
      exp_q.push_back(8'(i * 37 + 11));
      dbl_xfer(8'(i * 37 + 11));
    end
    cfg_mode = 2'd3; cyc(3);
    chk(mode_active == 2'd2, "R11 code 3 ignored", mode_active, 2);
    cfg_mode = 2'd1; cyc(3);
    for (int i = 0; i < 5; i++) begin
      exp_q.push_back(8'(i * 53 + 2));
      single_xfer(8'(i * 53 + 2));
    end
    cfg_mode = 2'd0; cyc(3);
    for (int i = 0; i < 5; i++) begin
      exp_q.push_back(8'(i * 29 + 200));
      strobe_byte(8'(i * 29 + 200));
    end
    cyc(10);
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule